// File: doc/BRIEF.md
# Dictionary-Coded Scan Stimulus Decompressor

This block sits between a narrow tester channel and a bank of parallel scan chains. The tester sends short codewords instead of whole scan slices. A codeword whose top bit is clear carries an index into a small on-chip table of chain-wide words. The selected word puts one bit on every scan chain in a single shift cycle. A codeword whose top bit is set is an escape. The slice that follows it arrives verbatim over a fixed number of codeword slots, so words that have no table entry can still be applied.

Before decompression starts, the table is filled through a write port. Each write goes to the next address of an internal counter. Every word the block applies raises the scan-enable for one cycle. After each run of chain-length words, a one-cycle pattern-done pulse marks the end of a scan pattern. The table holds words whose don't-care bits were already filled when it was built offline, so every applied bit is fully specified.

Top module: `dict_scan_decomp`

## Requirements
- R1: During and right after reset, `scan_en` and `pattern_done` are 0 and `scan_in` is all zeros.
- R2: Each cycle with `dict_we` high stores `dict_wdata` at the address held by a write counter. The counter starts at 0 after reset, advances by one per write and wraps after the last of the 2^(CODE_W-1) entries.
- R3: A codeword accepted with its top bit 0, while no raw word is being assembled, selects the table entry given by its low CODE_W-1 bits. That entry appears on `scan_in`, with `scan_en` high, exactly two clock edges after the codeword was sampled.
- R4: An accepted codeword with its top bit 1 is an escape, and its low bits are ignored. The next ceil(CHAINS/CODE_W) accepted codewords carry the raw word, the first slot holding the least significant bits. The raw word is applied two clock edges after its last slot is sampled.
- R5: While a raw word is incomplete, `scan_en` stays low, including across idle cycles between its slots.
- R6: `scan_en` is high for exactly one cycle per complete word and never without an accepted codeword two edges earlier.
- R7: `pattern_done` is high together with every CHAIN_LEN-th applied word and low otherwise; counting restarts after each pulse.
- R8: A codeword presented in a cycle where `dict_we` is high is ignored and produces no shift.
- R9: Codewords accepted on consecutive cycles produce words applied on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dict_we | input | 1 | Table write strobe (load mode) |
| dict_wdata | input | CHAINS | Word written to the table |
| cw_valid | input | 1 | Codeword present on `cw_data` |
| cw_data | input | CODE_W | Codeword from the tester; MSB is the escape flag |
| scan_in | output | CHAINS | One bit per scan chain, registered |
| scan_en | output | 1 | Chains shift this cycle |
| pattern_done | output | 1 | Last word of a scan pattern is being applied |

## Verification
Every applied word is due two clock edges after the codeword that completes it is sampled. For a table hit, that codeword is the index itself. For a raw word, it is the last slot. The bench drives codewords on falling edges, and a falling-edge monitor records each word with its pattern-done flag. Each scenario compares that record with a queue predicted from its own model of the table and the word count. A dedicated latency check shows the output still idle one edge after a codeword and the word present one edge later. For raw words with gaps between slots, the monitor record is inspected before the last slot to confirm that nothing has shifted.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic {
    SRC_DICT = 1'b0,
    SRC_RAW  = 1'b1
  } word_src_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/dcd_dict_ram.sv
module dcd_dict_ram #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcd_load_ctrl.sv
module dcd_load_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  output logic [AW-1:0] waddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      waddr <= '0;
    end else if (we) begin
      if (waddr == AW'(DEPTH - 1)) waddr <= '0;
      else                         waddr <= waddr + AW'(1);
    end
  end
endmodule

// File: rtl/dcd_cw_parser.sv
module dcd_cw_parser
  import dcd_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int CHAINS   = 8,
  localparam int IDX_W   = CODE_W - 1,
  localparam int SLOTS   = (CHAINS + CODE_W - 1) / CODE_W,
  localparam int SW      = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BUF_W   = SLOTS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_valid,
  input  logic [CODE_W-1:0] cw_data,
  input  logic              hold,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              s1_valid,
  output word_src_e         s1_src,
  output logic [CHAINS-1:0] s1_raw,
  output logic              busy
);
  logic              take;
  logic              flag;
  logic [SW-1:0]     slot;
  logic [BUF_W-1:0]  raw_buf;
  logic [BUF_W-1:0]  raw_nxt;
  logic              last_slot;

  assign take      = cw_valid && !hold;
  assign flag      = cw_data[CODE_W-1];
  assign rd_en     = take && !busy && !flag;
  assign rd_idx    = cw_data[IDX_W-1:0];
  assign last_slot = (slot == SW'(SLOTS - 1));

  always_comb begin
    raw_nxt = raw_buf;
    raw_nxt[slot*CODE_W +: CODE_W] = cw_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      slot     <= '0;
      raw_buf  <= '0;
      s1_valid <= 1'b0;
      s1_src   <= SRC_DICT;
      s1_raw   <= '0;
    end else begin
      s1_valid <= 1'b0;
      if (take) begin
        if (busy) begin
          raw_buf <= raw_nxt;
          if (last_slot) begin
            busy     <= 1'b0;
            slot     <= '0;
            s1_valid <= 1'b1;
            s1_src   <= SRC_RAW;
            s1_raw   <= raw_nxt[CHAINS-1:0];
          end else begin
            slot <= slot + SW'(1);
          end
        end else if (flag) begin
          busy    <= 1'b1;
          slot    <= '0;
          raw_buf <= '0;
        end else begin
          s1_valid <= 1'b1;
          s1_src   <= SRC_DICT;
        end
      end
    end
  end
endmodule

// File: rtl/dcd_scan_drive.sv
module dcd_scan_drive
  import dcd_pkg::*;
#(
  parameter int CHAINS    = 8,
  parameter int CHAIN_LEN = 4,
  localparam int CW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  word_src_e         s1_src,
  input  logic [CHAINS-1:0] s1_raw,
  input  logic [CHAINS-1:0] dict_q,
  output logic [CHAINS-1:0] scan_in,
  output logic              scan_en,
  output logic              pattern_done
);
  logic [CW-1:0] word_cnt;
  logic          at_end;

  assign at_end = (word_cnt == CW'(CHAIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_in      <= '0;
      scan_en      <= 1'b0;
      pattern_done <= 1'b0;
      word_cnt     <= '0;
    end else begin
      scan_en      <= s1_valid;
      pattern_done <= s1_valid && at_end;
      if (s1_valid) begin
        scan_in  <= (s1_src == SRC_RAW) ? s1_raw : dict_q;
        word_cnt <= at_end ? '0 : word_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dict_scan_decomp.sv
module dict_scan_decomp
  import dcd_pkg::*;
#(
  parameter int CHAINS    = 8,
  parameter int CODE_W    = 4,
  parameter int CHAIN_LEN = 4,
  localparam int IDX_W    = CODE_W - 1,
  localparam int DEPTH    = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dict_we,
  input  logic [CHAINS-1:0] dict_wdata,
  input  logic              cw_valid,
  input  logic [CODE_W-1:0] cw_data,
  output logic [CHAINS-1:0] scan_in,
  output logic              scan_en,
  output logic              pattern_done
);
  logic [IDX_W-1:0]  waddr;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [CHAINS-1:0] dict_q;
  logic              s1_valid;
  word_src_e         s1_src;
  logic [CHAINS-1:0] s1_raw;
  logic              asm_busy;

  dcd_load_ctrl #(.DEPTH(DEPTH)) u_load (
    .clk(clk), .rst(rst), .we(dict_we), .waddr(waddr)
  );

  dcd_dict_ram #(.WORD_W(CHAINS), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(dict_we), .waddr(waddr), .wdata(dict_wdata),
    .re(rd_en), .raddr(rd_idx), .rdata(dict_q)
  );

  dcd_cw_parser #(.CODE_W(CODE_W), .CHAINS(CHAINS)) u_parse (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_data(cw_data),
    .hold(dict_we), .rd_en(rd_en), .rd_idx(rd_idx),
    .s1_valid(s1_valid), .s1_src(s1_src), .s1_raw(s1_raw), .busy(asm_busy)
  );

  dcd_scan_drive #(.CHAINS(CHAINS), .CHAIN_LEN(CHAIN_LEN)) u_drive (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_src(s1_src),
    .s1_raw(s1_raw), .dict_q(dict_q), .scan_in(scan_in),
    .scan_en(scan_en), .pattern_done(pattern_done)
  );
endmodule

// File: rtl/dict_scan_decomp_chk.sv
module dict_scan_decomp_chk #(
  parameter int CHAIN_LEN = 4,
  localparam int CW       = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input logic clk,
  input logic rst,
  input logic dict_we,
  input logic cw_valid,
  input logic cw_flag,
  input logic asm_busy,
  input logic scan_en,
  input logic pattern_done
);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (scan_en) seen <= (seen == CW'(CHAIN_LEN - 1)) ? '0 : seen + CW'(1);
  end

  // R3: table hit applied two edges later
  p_dict_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && !dict_we && !cw_flag && !asm_busy) |-> ##2 scan_en);

  // R6: no shift without an accepted codeword two edges earlier
  p_shift_has_cause_r6: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> ($past(cw_valid, 2) && !$past(dict_we, 2)));

  // R8: codeword under a table write is dropped
  p_load_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    dict_we |-> ##2 !scan_en);

  // R7: pulse on every CHAIN_LEN-th word only
  p_done_position_r7: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> (pattern_done == (seen == CW'(CHAIN_LEN - 1))));

  p_done_needs_shift_r7: assert property (@(posedge clk) disable iff (rst)
    pattern_done |-> scan_en);

  // R5: escape alone never shifts
  p_escape_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && !dict_we && cw_flag && !asm_busy) |-> ##2 !scan_en);
endmodule

bind dict_scan_decomp dict_scan_decomp_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk(clk), .rst(rst), .dict_we(dict_we), .cw_valid(cw_valid),
  .cw_flag(cw_data[CODE_W-1]), .asm_busy(asm_busy),
  .scan_en(scan_en), .pattern_done(pattern_done)
);

// File: tb/dict_scan_decomp_tb.sv
module dict_scan_decomp_tb;
  localparam int PERIOD = 10;
  localparam int M = 8;
  localparam int B = 4;
  localparam int L = 4;
  localparam int DEPTH = 1 << (B - 1);

  logic         clk = 1'b0;
  logic         rst;
  logic         dict_we;
  logic [M-1:0] dict_wdata;
  logic         cw_valid;
  logic [B-1:0] cw_data;
  logic [M-1:0] scan_in;
  logic         scan_en;
  logic         pattern_done;

  int checks = 0;
  int fails  = 0;
  int words_out = 0;
  bit finished = 0;

  logic [M-1:0] model [DEPTH];
  logic [M-1:0] obs_w [$];
  logic         obs_d [$];
  logic [M-1:0] exp_w [$];
  logic         exp_d [$];

  always #(PERIOD/2) clk = ~clk;

  dict_scan_decomp #(.CHAINS(M), .CODE_W(B), .CHAIN_LEN(L)) u_dut (
    .clk(clk), .rst(rst), .dict_we(dict_we), .dict_wdata(dict_wdata),
    .cw_valid(cw_valid), .cw_data(cw_data), .scan_in(scan_in),
    .scan_en(scan_en), .pattern_done(pattern_done)
  );

  always @(negedge clk) begin
    if (!rst && scan_en) begin
      obs_w.push_back(scan_in);
      obs_d.push_back(pattern_done);
    end
  end

  function automatic logic [M-1:0] dval(input int i);
    return M'((i * 29) + 7) ^ M'(8'h5A);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_word(input logic [M-1:0] w);
    words_out++;
    exp_w.push_back(w);
    exp_d.push_back((words_out % L) == 0);
  endtask

  task automatic compare(input string req);
    check(obs_w.size() == exp_w.size(), req, "word count",
          M'(obs_w.size()), M'(exp_w.size()));
    if (obs_w.size() == exp_w.size()) begin
      for (int i = 0; i < exp_w.size(); i++) begin
        check(obs_w[i] == exp_w[i], req, "word", obs_w[i], exp_w[i]);
        check(obs_d[i] == exp_d[i], "R7", "pattern_done", M'(obs_d[i]), M'(exp_d[i]));
      end
    end
    obs_w.delete(); obs_d.delete(); exp_w.delete(); exp_d.delete();
  endtask

  task automatic send(input logic [B-1:0] cw);
    @(negedge clk);
    cw_valid = 1'b1;
    cw_data  = cw;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cw_valid = 1'b0;
    dict_we  = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; dict_we = 1'b0; dict_wdata = '0; cw_valid = 1'b0; cw_data = '0;
    repeat (3) @(negedge clk);
    check(!scan_en && !pattern_done && scan_in == '0, "R1", "reset outputs",
          {scan_en, pattern_done, scan_in[M-3:0]}, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!scan_en && !pattern_done && scan_in == '0, "R1", "after reset",
          scan_in, '0);
  endtask

  task automatic t_load;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      dict_we = 1'b1;
      dict_wdata = dval(i);
      model[i] = dval(i);
    end
    idle(3);
    check(obs_w.size() == 0, "R8", "no shift during load", M'(obs_w.size()), '0);
  endtask

  // R3 R9 R2: back-to-back table hits over every index
  task automatic t_decode_all;
    for (int i = 0; i < DEPTH; i++) begin
      send(B'(i));
      expect_word(model[i]);
    end
    idle(4);
    compare("R3");
  endtask

  // R3: exact latency
  task automatic t_latency;
    send(B'(5));
    @(negedge clk);
    cw_valid = 1'b0;
    check(scan_en == 1'b0, "R3", "one edge after", M'(scan_en), '0);
    @(negedge clk);
    check(scan_en == 1'b1 && scan_in == model[5], "R3", "two edges after",
          scan_in, model[5]);
    expect_word(model[5]);
    idle(2);
    compare("R3");
  endtask

  // R4 R5: raw word with gaps between slots
  task automatic t_raw;
    send(4'b1011);
    idle(2);
    send(4'hC);
    idle(4);
    check(obs_w.size() == 0, "R5", "no shift while assembling", M'(obs_w.size()), '0);
    send(4'h3);
    expect_word(8'h3C);
    idle(4);
    compare("R4");
  endtask

  // R8 R2: codeword under write is dropped, write address wraps
  task automatic t_collide;
    @(negedge clk);
    dict_we = 1'b1; dict_wdata = 8'hC3;
    cw_valid = 1'b1; cw_data = B'(1);
    model[0] = 8'hC3;
    idle(4);
    check(obs_w.size() == 0, "R8", "dropped codeword", M'(obs_w.size()), '0);
    send(B'(0)); expect_word(model[0]);
    send(B'(1)); expect_word(model[1]);
    idle(4);
    compare("R2");
  endtask

  // R9 R4 R7: mixed stream, raw slot bits with flag set are data
  task automatic t_mixed;
    send(B'(2)); expect_word(model[2]);
    send(4'b1000);
    send(4'hF);
    send(4'h9); expect_word(8'h9F);
    send(B'(7)); expect_word(model[7]);
    send(4'b1111);
    send(4'h0);
    send(4'hA); expect_word(8'hA0);
    send(B'(3)); expect_word(model[3]);
    idle(4);
    compare("R9");
  endtask

  initial begin
    t_reset;
    t_load;
    t_decode_all;
    t_latency;
    t_raw;
    t_collide;
    t_mixed;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule